// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This unit decides whether a conditional trap instruction fires. It takes two operands, a five-bit condition mask and a width select, and evaluates five relations between the operands at once: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. Each mask bit enables one relation. If any enabled relation holds, the unit raises a trap request.

In doubleword mode the full 64-bit operands are compared. In word mode only the low 32 bits of each operand take part, and bit 31 acts as the sign for the signed relations. The result is registered. It appears one cycle after the valid strobe, together with a cause code that classifies the event as a program-class trap. The exception entry sequence that consumes the request is outside this unit.

Top module: `trapcmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when A is less than B, with both operands read as two's-complement signed values.
- R2: Mask bit 3 (value 0x08) enables a trap when A is greater than B, with both operands read as signed values.
- R3: Mask bit 2 (value 0x04) enables a trap when A equals B. For any operand pair, exactly one of signed-less, signed-greater and equal holds.
- R4: Mask bit 1 (value 0x02) enables a trap when A is less than B, with both operands read as unsigned values.
- R5: Mask bit 0 (value 0x01) enables a trap when A is greater than B, with both operands read as unsigned values.
- R6: When `dword_mode` is 0, bits 63:32 of both operands have no effect on the result, and bit 31 is the sign bit for R1 and R2. When `dword_mode` is 1, all 64 bits take part and bit 63 is the sign bit.
- R7: When several mask bits are set, the trap is the OR of the enabled relations.
- R8: A mask of 0x00 never traps. A mask of 0x1F always traps.
- R9: `res_valid` is high exactly one cycle after `in_valid` is high. `trap_req` is 0 whenever `res_valid` is 0.
- R10: `trap_cause` is 8'h21 when `trap_req` is 1 and 8'h00 otherwise. The upper nibble 2 marks the program class and the lower nibble 1 marks the trap sub-code.
- R11: While `rst` is high, and at the first edge after it is released, `res_valid`, `trap_req` and `trap_cause` are all zero, whatever the other inputs are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mask are valid this cycle |
| opnd_a | input | 64 | First operand (A) |
| opnd_b | input | 64 | Second operand (B) |
| cond_mask | input | 5 | Relation enables: bit 4 signed <, bit 3 signed >, bit 2 equal, bit 1 unsigned <, bit 0 unsigned > |
| dword_mode | input | 1 | 1 = 64-bit compare, 0 = 32-bit word compare on the low halves |
| res_valid | output | 1 | Registered result is valid |
| trap_req | output | 1 | A trap is requested |
| trap_cause | output | 8 | Cause code: 8'h21 on a trap, 8'h00 otherwise |

## Verification
Two kinds of events can fall in the same cycle.

The first is a signed relation and an unsigned relation giving opposite answers for one operand pair. An operand with its sign bit set compares low as signed and high as unsigned. The bench provokes this with mixed-sign pairs such as -1 against 1, in both word and doubleword mode. It selects either side of the disagreement through the mask and judges each outcome against an independent reference model.

The second is a new operand pair being captured on the same edge that presents the previous result. The bench streams operations back to back, with no idle cycle between them. A queue-based scoreboard then confirms that every result belongs to its own request and that no result is dropped or duplicated.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;

    // Number of relation enables in the condition mask
    localparam int MASK_W = 5;

    // Mask bit positions; software encodes the condition in this order
    localparam int BIT_SLT = 4;
    localparam int BIT_SGT = 3;
    localparam int BIT_EQ  = 2;
    localparam int BIT_ULT = 1;
    localparam int BIT_UGT = 0;

    typedef enum logic [3:0] {
        CLS_NONE    = 4'h0,
        CLS_PROGRAM = 4'h2
    } cause_cls_e;

    typedef enum logic [3:0] {
        SUB_NONE = 4'h0,
        SUB_TRAP = 4'h1
    } cause_sub_e;

    typedef struct packed {
        cause_cls_e cls;
        cause_sub_e sub;
    } cause_t;

    localparam int CAUSE_W = $bits(cause_t);

    // Relation flags, packed in mask bit order so a bitwise AND selects them
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_t;

    typedef struct packed {
        logic   valid;
        logic   trap;
        cause_t cause;
    } result_t;

    function automatic cause_t make_cause(input logic trap);
        cause_t c;
        if (trap) begin
            c.cls = CLS_PROGRAM;
            c.sub = SUB_TRAP;
        end else begin
            c.cls = CLS_NONE;
            c.sub = SUB_NONE;
        end
        return c;
    endfunction

    function automatic result_t idle_result();
        result_t r;
        r.valid = 1'b0;
        r.trap  = 1'b0;
        r.cause = make_cause(1'b0);
        return r;
    endfunction

endpackage

// File: rtl/trapcmp_narrow.sv
// Operand conditioning: picks the compare width and extracts the sign bits.
module trapcmp_narrow #(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              dword,
    output logic [DATA_W-1:0] a_mag,
    output logic [DATA_W-1:0] b_mag,
    output logic              a_sign,
    output logic              b_sign
);
    localparam int HI_W = DATA_W - WORD_W;

    generate
        if (HI_W > 0) begin : g_split
            always_comb begin
                if (dword) begin
                    a_mag  = a_in;
                    b_mag  = b_in;
                    a_sign = a_in[DATA_W-1];
                    b_sign = b_in[DATA_W-1];
                end else begin
                    // Upper half cleared; signed order then comes from bit WORD_W-1
                    a_mag  = {{HI_W{1'b0}}, a_in[WORD_W-1:0]};
                    b_mag  = {{HI_W{1'b0}}, b_in[WORD_W-1:0]};
                    a_sign = a_in[WORD_W-1];
                    b_sign = b_in[WORD_W-1];
                end
            end
        end else begin : g_full
            logic unused_mode;
            assign unused_mode = dword;
            assign a_mag  = a_in;
            assign b_mag  = b_in;
            assign a_sign = a_in[DATA_W-1];
            assign b_sign = b_in[DATA_W-1];
        end
    endgenerate

endmodule

// File: rtl/trapcmp_relate.sv
// One shared subtractor produces all five relations.
module trapcmp_relate
    import trapcmp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_mag,
    input  logic [DATA_W-1:0] b_mag,
    input  logic              a_sign,
    input  logic              b_sign,
    output rel_t              rel
);
    logic [DATA_W:0] diff;
    logic            borrow;
    logic            zero;
    logic            s_less;

    always_comb begin
        diff   = {1'b0, a_mag} - {1'b0, b_mag};
        borrow = diff[DATA_W];
        zero   = (diff[DATA_W-1:0] == '0);
        // Equal signs: unsigned order is signed order. Different signs: the negative one is smaller.
        s_less = (a_sign ^ b_sign) ? a_sign : borrow;

        rel.ult = borrow;
        rel.eq  = zero;
        rel.ugt = ~borrow & ~zero;
        rel.slt = s_less;
        rel.sgt = ~s_less & ~zero;
    end

endmodule

// File: rtl/trapcmp_select.sv
// Applies the condition mask and OR-reduces the enabled relations.
module trapcmp_select
    import trapcmp_pkg::*;
(
    input  rel_t              rel,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);
    logic [MASK_W-1:0] rel_bits;
    logic [MASK_W-1:0] enabled;

    assign rel_bits = rel;

    genvar gi;
    generate
        for (gi = 0; gi < MASK_W; gi++) begin : g_gate
            assign enabled[gi] = rel_bits[gi] & mask[gi];
        end
    endgenerate

    assign hit = |enabled;

endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
    import trapcmp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         opnd_a,
    input  logic [DATA_W-1:0]         opnd_b,
    input  logic [trapcmp_pkg::MASK_W-1:0]  cond_mask,
    input  logic                      dword_mode,
    output logic                      res_valid,
    output logic                      trap_req,
    output logic [trapcmp_pkg::CAUSE_W-1:0] trap_cause
);
    logic [DATA_W-1:0] a_mag, b_mag;
    logic              a_sign, b_sign;
    rel_t              rel;
    logic              hit;
    result_t           res_d, res_q;

    trapcmp_narrow #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_narrow (
        .a_in   (opnd_a),
        .b_in   (opnd_b),
        .dword  (dword_mode),
        .a_mag  (a_mag),
        .b_mag  (b_mag),
        .a_sign (a_sign),
        .b_sign (b_sign)
    );

    trapcmp_relate #(.DATA_W(DATA_W)) u_relate (
        .a_mag  (a_mag),
        .b_mag  (b_mag),
        .a_sign (a_sign),
        .b_sign (b_sign),
        .rel    (rel)
    );

    trapcmp_select u_select (
        .rel  (rel),
        .mask (cond_mask),
        .hit  (hit)
    );

    always_comb begin
        res_d       = idle_result();
        res_d.valid = in_valid;
        res_d.trap  = in_valid & hit;
        res_d.cause = make_cause(in_valid & hit);
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= idle_result();
        else     res_q <= res_d;
    end

    assign res_valid  = res_q.valid;
    assign trap_req   = res_q.trap;
    assign trap_cause = res_q.cause;

    // R9: one-cycle latency, result qualified by valid
    a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);
    a_r9_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);
    a_r9_trap_needs_valid: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> res_valid);
    // R10: cause code follows the trap flag
    a_r10_cause_on_trap: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> trap_cause == 8'h21);
    a_r10_cause_idle: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> trap_cause == 8'h00);
    // R8: boundary masks
    a_r8_full_mask_traps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_mask == 5'h1F) |=> trap_req);
    a_r8_zero_mask_quiet: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cond_mask == 5'h00) |=> !trap_req);
    // R3: signed trichotomy and unsigned trichotomy among the relation flags
    a_r3_signed_trichotomy: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $countones({rel.slt, rel.sgt, rel.eq}) == 1);
    a_r3_unsigned_trichotomy: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $countones({rel.ult, rel.ugt, rel.eq}) == 1);
    // R11: outputs clear after a reset edge
    a_r11_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!res_valid && !trap_req && trap_cause == 8'h00));

endmodule

// File: tb/trapcmp_unit_tb_top.sv
module trapcmp_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] opnd_a, opnd_b;
    logic [4:0]  cond_mask;
    logic        dword_mode;
    logic        res_valid, trap_req;
    logic [7:0]  trap_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_trap_q[$];
    string exp_req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trapcmp_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .cond_mask  (cond_mask),
        .dword_mode (dword_mode),
        .res_valid  (res_valid),
        .trap_req   (trap_req),
        .trap_cause (trap_cause)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements
    function automatic bit ref_trap(input logic [63:0] a, input logic [63:0] b,
                                    input logic [4:0] m, input logic dw);
        logic signed [63:0] sa, sb;
        logic        [63:0] ua, ub;
        if (dw) begin
            sa = a; sb = b; ua = a; ub = b;
        end else begin
            sa = {{32{a[31]}}, a[31:0]};
            sb = {{32{b[31]}}, b[31:0]};
            ua = {32'h0, a[31:0]};
            ub = {32'h0, b[31:0]};
        end
        return (m[4] && (sa < sb)) || (m[3] && (sa > sb)) || (m[2] && (ua == ub)) ||
               (m[1] && (ua < ub)) || (m[0] && (ua > ub));
    endfunction

    task automatic send(input logic [63:0] a, input logic [63:0] b,
                        input logic [4:0] m, input logic dw, input string req);
        @(negedge clk);
        in_valid   = 1'b1;
        opnd_a     = a;
        opnd_b     = b;
        cond_mask  = m;
        dword_mode = dw;
        exp_trap_q.push_back(ref_trap(a, b, m, dw));
        exp_req_q.push_back(req);
    endtask

    task automatic send_exp(input logic [63:0] a, input logic [63:0] b,
                            input logic [4:0] m, input logic dw,
                            input bit want, input string req);
        // Hand-computed expectation is cross-checked against the model
        check(ref_trap(a, b, m, dw) == want, req, "model", 64'(ref_trap(a, b, m, dw)), 64'(want));
        send(a, b, m, dw, req);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            opnd_a   = 64'hDEAD_BEEF_0BAD_F00D;
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                if (exp_trap_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected result", 64'(res_valid), 64'h0);
                end else begin
                    bit    et;
                    string er;
                    et = exp_trap_q.pop_front();
                    er = exp_req_q.pop_front();
                    check(trap_req == et, er, "trap_req", 64'(trap_req), 64'(et));
                    check(trap_cause == (et ? 8'h21 : 8'h00), "R10", "trap_cause",
                          64'(trap_cause), et ? 64'h21 : 64'h0);
                end
            end else begin
                check(trap_req == 1'b0, "R9", "trap without valid", 64'(trap_req), 64'h0);
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        in_valid   = 1'b1;
        opnd_a     = '0;
        opnd_b     = '0;
        cond_mask  = 5'h1F;
        dword_mode = 1'b1;
        repeat (4) @(negedge clk);
        // R11: valid and full mask applied during reset must leave outputs clear
        check(res_valid == 1'b0, "R11", "res_valid in reset", 64'(res_valid), 64'h0);
        check(trap_req == 1'b0, "R11", "trap_req in reset", 64'(trap_req), 64'h0);
        check(trap_cause == 8'h00, "R11", "cause in reset", 64'(trap_cause), 64'h0);
        in_valid = 1'b0;
        rst      = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R11", "res_valid after reset", 64'(res_valid), 64'h0);

        // R1: signed less-than
        send_exp(-64'sd5, 64'sd3, 5'h10, 1'b1, 1'b1, "R1");
        send_exp(64'sd3, -64'sd5, 5'h10, 1'b1, 1'b0, "R1");
        // R2: signed greater-than
        send_exp(64'sd3, -64'sd5, 5'h08, 1'b1, 1'b1, "R2");
        send_exp(-64'sd5, 64'sd3, 5'h08, 1'b1, 1'b0, "R2");
        // R3: equality
        send_exp(64'h1234, 64'h1234, 5'h04, 1'b1, 1'b1, "R3");
        send_exp(64'h1234, 64'h1235, 5'h04, 1'b1, 1'b0, "R3");
        idle(2);
        // R4: unsigned less-than, where signed and unsigned order disagree
        send_exp(64'd1, '1, 5'h02, 1'b1, 1'b1, "R4");
        send_exp('1, 64'd1, 5'h02, 1'b1, 1'b0, "R4");
        // R5: unsigned greater-than
        send_exp('1, 64'd1, 5'h01, 1'b1, 1'b1, "R5");
        send_exp(64'd1, '1, 5'h01, 1'b1, 1'b0, "R5");
        // R6: word mode ignores the upper half
        send_exp(64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b0, 1'b1, "R6");
        send_exp(64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b1, 1'b0, "R6");
        send_exp(64'h0000_0000_8000_0000, 64'h1, 5'h10, 1'b0, 1'b1, "R6");
        send_exp(64'h0000_0000_8000_0000, 64'h1, 5'h10, 1'b1, 1'b0, "R6");
        send_exp(64'h0000_0001_0000_0000, 64'h1, 5'h01, 1'b0, 1'b0, "R6");
        send_exp(64'h0000_0001_0000_0000, 64'h1, 5'h01, 1'b1, 1'b1, "R6");
        idle(1);
        // R7: several relations enabled, OR of the results
        send_exp('1, 64'd1, 5'h12, 1'b1, 1'b1, "R7");
        send_exp('1, 64'd1, 5'h0A, 1'b1, 1'b0, "R7");
        send_exp('1, 64'd1, 5'h09, 1'b1, 1'b1, "R7");
        // R8: boundary masks
        send_exp(64'h77, 64'h77, 5'h00, 1'b1, 1'b0, "R8");
        send_exp(64'h10, 64'h77, 5'h00, 1'b0, 1'b0, "R8");
        send_exp(64'h10, 64'h77, 5'h1F, 1'b1, 1'b1, "R8");
        send_exp(64'h77, 64'h77, 5'h1F, 1'b0, 1'b1, "R8");
        // R9: back-to-back stream with gaps, checked by the scoreboard
        for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            b = (i % 7 == 0) ? a : {$urandom(), $urandom()};
            if (i % 5 == 0) b[31:0] = a[31:0];
            send(a, b, 5'($urandom()), 1'($urandom()), "R7");
            if (i % 11 == 0) idle(1 + (i % 3));
        end
        idle(4);
        check(exp_trap_q.size() == 0, "R9", "results outstanding",
              64'(exp_trap_q.size()), 64'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule